// File: doc/BRIEF.md
# Power Button Override Controller

This block watches an active-low power button pin together with the platform's current sleep state. It filters the raw pin, and it reports the filtered level so software can see whether the button is down right now. When the platform sits in a suspend state, a fresh press raises a one-cycle wake request. The one exception is while the sleep-signal minimum-width stretch is running: a press then produces no wake.

In parallel, a held button drives an override timer. The timer counts whole seconds from a prescaler fed by the input clock. When the hold reaches the threshold for the current state, the block emits a single-cycle force-off pulse. The platform's sequencer must then go to soft-off with no further handshake. The threshold is short in the running and light-sleep states and long in the deeper suspend states. The longer value lets a wake that was held back by the stretch arrive before an override fires. The power-good input plays no part in this decision.

Top module: `pwrbtn_override_ctrl`

## Requirements
- R1: The raw pin (`btn_n_i`, 0 = pressed) is synchronised, and `level_o` changes only after the synchronised value has differed from it for `DB_SAMPLES` consecutive cycles. A shorter glitch leaves `level_o` unchanged. `level_o` = 1 means pressed.
- R2: With `sleep_state_i` = 0 (S0) or 1 (S1), `force_off_o` pulses exactly `SHORT_SEC*CLK_HZ` cycles after `level_o` rises, provided the press is continuous.
- R3: With `sleep_state_i` = 3 (S3) or 4 (S4), the threshold is `LONG_SEC*CLK_HZ` cycles. A press in these states that is shorter than the long threshold but longer than the short one produces no force-off.
- R4: A release before the threshold clears the timer, so the next press counts again from zero.
- R5: `force_off_o` is high for one cycle only. It fires at most once per press and does not re-arm until `level_o` has fallen.
- R6: `pwr_ok_i` has no effect on the force-off decision or its timing.
- R7: A rising edge of `level_o` while `sleep_state_i` is 1 to 5 produces exactly one `wake_o` pulse, one cycle after the edge, however long the button stays down.
- R8: No `wake_o` pulse is produced if `stretch_i` is high at the press edge, or if `sleep_state_i` = 0.
- R9: With `sleep_state_i` = 2, 5, 6 or 7, the override timer does not run and no force-off occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, `CLK_HZ` cycles per second |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_n_i | input | 1 | Raw power button pin, active low |
| sleep_state_i | input | 3 | Current sleep state code (0..5 = S0..S5) |
| stretch_i | input | 1 | Sleep-signal minimum-width stretch in progress |
| pwr_ok_i | input | 1 | Power-good indication (ignored for override) |
| level_o | output | 1 | Filtered button level, 1 = pressed |
| wake_o | output | 1 | One-cycle wake request |
| force_off_o | output | 1 | One-cycle forced soft-off request |

## Verification
The hardest case to reach is a hold that outlasts the short threshold but not the long one while the platform is in a deep suspend state. Such a hold must produce a wake but no override, and a second press must not inherit the time already counted. The bench sets the state code before the press and holds the pin for a chosen number of cycles between the two thresholds. A scaled clock rate makes a second only ten cycles long. The bench then releases the pin and presses again so that the two partial holds add up to more than the short threshold. Repeated holds far beyond the threshold confirm that exactly one force-off is produced per press.

// File: rtl/pbo_pkg.sv
package pbo_pkg;

  typedef enum logic [1:0] {
    THR_NONE  = 2'd0,
    THR_SHORT = 2'd1,
    THR_LONG  = 2'd2
  } thr_sel_e;

  localparam logic [2:0] ST_S0 = 3'd0;
  localparam logic [2:0] ST_S1 = 3'd1;
  localparam logic [2:0] ST_S3 = 3'd3;
  localparam logic [2:0] ST_S4 = 3'd4;
  localparam logic [2:0] ST_S5 = 3'd5;

  function automatic thr_sel_e thr_of_state(input logic [2:0] st);
    case (st)
      ST_S0, ST_S1: return THR_SHORT;
      ST_S3, ST_S4: return THR_LONG;
      default:      return THR_NONE;
    endcase
  endfunction

  function automatic logic is_suspend(input logic [2:0] st);
    return (st >= ST_S1) && (st <= ST_S5);
  endfunction

endpackage

// File: rtl/pbo_debounce.sv
module pbo_debounce #(
  parameter int unsigned DB_SAMPLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_n_i,
  output logic level_o
);
  localparam int unsigned CW = (DB_SAMPLES < 2) ? 1 : $clog2(DB_SAMPLES);
  localparam logic [CW-1:0] LAST = CW'(DB_SAMPLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level_q;
  logic                   smp;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], ~raw_n_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (smp == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      level_q <= smp;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = level_q;

  // R1
  level_follows_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(smp) == level_q));

endmodule

// File: rtl/pbo_sec_tick.sv
module pbo_sec_tick #(
  parameter int unsigned CLK_HZ = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLK_HZ < 2) ? 1 : $clog2(CLK_HZ);
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(run_i));

endmodule

// File: rtl/pbo_override.sv
module pbo_override
  import pbo_pkg::*;
#(
  parameter int unsigned SHORT_SEC = 4,
  parameter int unsigned LONG_SEC  = 9
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pressed_i,
  input  thr_sel_e thr_i,
  input  logic     tick_i,
  output logic     run_o,
  output logic     force_o
);
  localparam int unsigned MAXS = (LONG_SEC > SHORT_SEC) ? LONG_SEC : SHORT_SEC;
  localparam int unsigned SW   = $clog2(MAXS + 1);
  localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_SEC - 1);
  localparam logic [SW-1:0] LONG_LAST  = SW'(LONG_SEC - 1);

  logic [SW-1:0] sec_q;
  logic [SW-1:0] last;
  logic          done_q;
  logic          force_q;

  assign last  = (thr_i == THR_LONG) ? LONG_LAST : SHORT_LAST;
  assign run_o = pressed_i && !done_q && (thr_i != THR_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '0;
      done_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      force_q <= 1'b0;
      if (!pressed_i) done_q <= 1'b0;
      if (!run_o) begin
        sec_q <= '0;
      end else if (tick_i) begin
        // state may drop to the short limit mid-hold: fire on >=
        if (sec_q >= last) begin
          sec_q   <= '0;
          force_q <= 1'b1;
          done_q  <= 1'b1;
        end else begin
          sec_q <= sec_q + 1'b1;
        end
      end
    end
  end

  assign force_o = force_q;

  // R5
  force_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q |=> !force_q);

  // R5
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_q && pressed_i) |=> !run_o);

  // R9
  force_needs_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_q |-> $past(thr_i != THR_NONE && pressed_i));

endmodule

// File: rtl/pwrbtn_override_ctrl.sv
module pwrbtn_override_ctrl
  import pbo_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 1000000,
  parameter int unsigned DB_SAMPLES = 16,
  parameter int unsigned SHORT_SEC  = 4,
  parameter int unsigned LONG_SEC   = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       btn_n_i,
  input  logic [2:0] sleep_state_i,
  input  logic       stretch_i,
  input  logic       pwr_ok_i,
  output logic       level_o,
  output logic       wake_o,
  output logic       force_off_o
);
  logic     level;
  logic     level_d_q;
  logic     press_rise;
  logic     wake_q;
  logic     run;
  logic     tick;
  thr_sel_e thr;
  logic     pwr_ok_unused;

  assign pwr_ok_unused = pwr_ok_i;

  pbo_debounce #(.DB_SAMPLES(DB_SAMPLES)) u_db (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_n_i (btn_n_i),
    .level_o (level)
  );

  assign thr = thr_of_state(sleep_state_i);

  pbo_sec_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  pbo_override #(.SHORT_SEC(SHORT_SEC), .LONG_SEC(LONG_SEC)) u_ovr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pressed_i (level),
    .thr_i     (thr),
    .tick_i    (tick),
    .run_o     (run),
    .force_o   (force_off_o)
  );

  assign press_rise = level && !level_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_d_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      level_d_q <= level;
      wake_q    <= press_rise && is_suspend(sleep_state_i) && !stretch_i;
    end
  end

  assign level_o = level;
  assign wake_o  = wake_q;

  // R8
  wake_not_in_stretch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(!stretch_i && sleep_state_i != ST_S0));

  // R7
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R7
  wake_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(level_o));

endmodule

// File: tb/pwrbtn_override_ctrl_test.sv
module pwrbtn_override_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 10;
  localparam int DB = 4;
  localparam int SS = 4;
  localparam int LS = 9;

  logic clk = 0, rst_n = 0, btn_n = 1, stretch = 0, pwr_ok = 1;
  logic [2:0] st = 0;
  logic level, wake, force_off;

  int checks = 0, errors = 0;
  int cyc = 0, rise_cyc = -1, force_cyc = -1;
  int n_wake = 0, n_force = 0, n_rise = 0;
  logic level_prev = 0;

  pwrbtn_override_ctrl #(.CLK_HZ(HZ), .DB_SAMPLES(DB), .SHORT_SEC(SS), .LONG_SEC(LS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .btn_n_i(btn_n), .sleep_state_i(st),
    .stretch_i(stretch), .pwr_ok_i(pwr_ok), .level_o(level),
    .wake_o(wake), .force_off_o(force_off));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (level && !level_prev) begin n_rise <= n_rise + 1; if (rise_cyc < 0) rise_cyc <= cyc; end
    level_prev <= level;
    if (wake) n_wake <= n_wake + 1;
    if (force_off) begin n_force <= n_force + 1; if (force_cyc < 0) force_cyc <= cyc; end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    n_wake = 0; n_force = 0; n_rise = 0; rise_cyc = -1; force_cyc = -1;
  endtask

  task automatic hold(input int cycles);
    btn_n = 0;
    repeat (cycles) @(negedge clk);
    btn_n = 1;
    repeat (DB + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset level", int'(level), 0);
    check("R7 reset wake", int'(wake), 0);
    check("R5 reset force", int'(force_off), 0);
  endtask

  task automatic t_glitch();
    clear_mon();
    btn_n = 0; repeat (2) @(negedge clk); btn_n = 1;
    repeat (10) @(negedge clk);
    check("R1 glitch ignored", n_rise, 0);
  endtask

  task automatic t_short(input logic [2:0] s, input int exp_wake, input string r);
    clear_mon(); st = s;
    hold(SS*HZ + 20);
    check({r, " force count"}, n_force, 1);
    check({r, " force delay"}, force_cyc - rise_cyc, SS*HZ);
    check("R7 wake count", n_wake, exp_wake);
  endtask

  task automatic t_long_state(input logic [2:0] s);
    clear_mon(); st = s;
    hold(SS*HZ + 20);
    check("R3 no force below long", n_force, 0);
    check("R7 wake in deep suspend", n_wake, 1);
    clear_mon();
    hold(LS*HZ + 20);
    check("R3 force count", n_force, 1);
    check("R3 force delay", force_cyc - rise_cyc, LS*HZ);
  endtask

  task automatic t_split();
    clear_mon(); st = 0;
    hold(SS*HZ - 8);
    hold(SS*HZ - 8);
    check("R4 split press no force", n_force, 0);
    check("R4 two presses seen", n_rise, 2);
  endtask

  task automatic t_long_hold();
    clear_mon(); st = 0;
    hold(SS*HZ*5);
    check("R5 one force per press", n_force, 1);
  endtask

  task automatic t_pwr_bad();
    clear_mon(); st = 1; pwr_ok = 0;
    hold(SS*HZ + 20);
    check("R6 force without pwr ok", n_force, 1);
    check("R6 delay without pwr ok", force_cyc - rise_cyc, SS*HZ);
    pwr_ok = 1;
  endtask

  task automatic t_stretch();
    clear_mon(); st = 5; stretch = 1;
    hold(30);
    check("R8 no wake in stretch", n_wake, 0);
    stretch = 0;
    clear_mon();
    hold(30);
    check("R7 wake from S5", n_wake, 1);
  endtask

  task automatic t_no_timer(input logic [2:0] s);
    clear_mon(); st = s;
    hold(LS*HZ + 30);
    check("R9 no override", n_force, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_glitch();
    t_short(3'd0, 0, "R2 S0");
    t_short(3'd1, 1, "R2 S1");
    t_long_state(3'd3);
    t_long_state(3'd4);
    t_split();
    t_long_hold();
    t_pwr_bad();
    t_stretch();
    t_no_timer(3'd5);
    t_no_timer(3'd2);
    t_no_timer(3'd7);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule